// File: doc/BRIEF.md
# Shared-Source Edge Interrupt Gate

This block produces a single interrupt request for a CPU from one of two candidate sources: an external pin and the output of an internal comparator. A select bit in a byte-wide register chooses which source feeds the block. The chosen signal is sampled once per clock. A 0-to-1 change between two consecutive samples sets a pending flag. Because the edge detector sits after the source multiplexer, changing the select bit can itself raise a request. Software is expected to turn interrupts off before it switches sources.

A second byte register holds a master enable. The CPU's enable-interrupts, interrupt-return, disable-interrupts and acknowledge strobes set and clear this bit, and so do direct register writes and reset. The request output is high only while a request is pending and the master enable is set. A request that arrives while interrupts are disabled stays recorded. It is presented as soon as interrupts are enabled again. Both registers are reached through a simple byte port. Writes are synchronous and reads are combinational.

Top module: `irq_gate`

## Requirements
- R1: After reset, both registers read 0x00 and `irqReq` is 0.
- R2: The select register is at address 0. Bit 6 chooses the source: 0 selects `pinIn` and 1 selects `cmpIn`. All other bits are ignored on write and read as 0, so writing 0xFF reads back 0x40.
- R3: A 0-to-1 change of the selected source between two consecutive clock samples sets the pending flag at that clock edge. Changes on the unselected source have no effect.
- R4: A write to the select bit sets the pending flag one clock after the write if the new source is 1 and the old source was 0.
- R5: The control register is at address 1, and bit 7 is the master enable. `eiStb`, `iretStb`, or a write of 1 to bit 7 sets it. Bits 6 to 0 read as 0, so writing 0xFF reads back 0x80.
- R6: `diStb`, `ackStb`, reset, or a write of 0 to bit 7 clears the master enable.
- R7: When a set and a clear of the master enable occur in the same cycle, the clear wins. When any of the four strobes is active, a control-register write in the same cycle is ignored.
- R8: `irqReq` equals the pending flag AND the master enable. The pending flag is still set by edges while the enable is 0.
- R9: `ackStb` clears the pending flag and the master enable in the same cycle. If a qualifying edge occurs in the acknowledge cycle, the pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 1 | Register address (0 = select, 1 = control) |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| pinIn | input | 1 | External pin source |
| cmpIn | input | 1 | Comparator source |
| eiStb | input | 1 | Enable-interrupts strobe |
| iretStb | input | 1 | Interrupt-return strobe |
| diStb | input | 1 | Disable-interrupts strobe |
| ackStb | input | 1 | CPU acknowledge strobe |
| irqReq | output | 1 | Interrupt request to the CPU |

## Verification
A wrong master-enable state appears on the control register's bit 7 as soon as the register is read after the clock edge that should have changed it. `irqReq` also shows the error immediately whenever a request is pending. A wrong pending flag or edge sample is not readable directly. It shows on `irqReq` within one clock of the next enable, so each edge case is followed by an acknowledge and an enable to expose it. A multiplexer that tracks the wrong source shows as a missing or extra request one clock after the input or select change.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  typedef struct packed {
    logic selWr;    // update source select
    logic selVal;   // new select value
    logic enWr;     // register write to master enable (already yielded)
    logic enVal;    // written master enable value
    logic setEn;    // instruction set of master enable
    logic clrEn;    // instruction/acknowledge clear of master enable
    logic clrPend;  // acknowledge clears pending
  } gateStrb_t;
endpackage

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 1,
  parameter int SEL_BIT   = 6,
  parameter int EN_BIT    = 7,
  parameter int SEL_ADDR  = 0,
  parameter int CTRL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              eiStb,
  input  logic              iretStb,
  input  logic              diStb,
  input  logic              ackStb,
  output gateStrb_t         strb
);
  localparam logic [ADDR_W-1:0] SelA  = ADDR_W'(SEL_ADDR);
  localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(CTRL_ADDR);

  logic anyStrobe;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData;
  assign anyStrobe    = eiStb | iretStb | diStb | ackStb;

  always_comb begin
    strb         = '0;
    strb.selWr   = regWrEn && (regAddr == SelA);
    strb.selVal  = regWrData[SEL_BIT];
    strb.enWr    = regWrEn && (regAddr == CtrlA) && !anyStrobe;
    strb.enVal   = regWrData[EN_BIT];
    strb.setEn   = eiStb | iretStb;
    strb.clrEn   = diStb | ackStb;
    strb.clrPend = ackStb;
  end

  AST_WRITE_YIELDS: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> !strb.enWr); // R7
endmodule

// File: rtl/irq_gate_dp.sv
module irq_gate_dp
  import irq_gate_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 1,
  parameter int SEL_BIT   = 6,
  parameter int EN_BIT    = 7,
  parameter int CTRL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrb_t         strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              pinIn,
  input  logic              cmpIn,
  output logic [DATA_W-1:0] regRdData,
  output logic              enable,
  output logic              pending,
  output logic              irqReq
);
  localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(CTRL_ADDR);

  logic selReg;
  logic enReg;
  logic pendReg;
  logic lastSample;
  logic muxOut;
  logic riseSeen;

  assign muxOut   = selReg ? cmpIn : pinIn;
  assign riseSeen = muxOut & ~lastSample;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg     <= 1'b0;
      enReg      <= 1'b0;
      pendReg    <= 1'b0;
      lastSample <= 1'b0;
    end else begin
      lastSample <= muxOut;
      if (strb.selWr) selReg <= strb.selVal;
      pendReg <= riseSeen | (pendReg & ~strb.clrPend);
      if (strb.clrEn)      enReg <= 1'b0;
      else if (strb.setEn) enReg <= 1'b1;
      else if (strb.enWr)  enReg <= strb.enVal;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == CtrlA) regRdData[EN_BIT]  = enReg;
    else                  regRdData[SEL_BIT] = selReg;
  end

  assign enable  = enReg;
  assign pending = pendReg;
  assign irqReq  = pendReg & enReg;

  AST_RISE_PENDS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(muxOut) |=> pendReg); // R3
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (pendReg && !strb.clrPend) |=> pendReg); // R9
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_gate_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 1,
  parameter int SEL_BIT   = 6,
  parameter int EN_BIT    = 7,
  parameter int SEL_ADDR  = 0,
  parameter int CTRL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              pinIn,
  input  logic              cmpIn,
  input  logic              eiStb,
  input  logic              iretStb,
  input  logic              diStb,
  input  logic              ackStb,
  output logic              irqReq
);
  gateStrb_t strb;
  logic      enable;
  logic      pending;

  irq_gate_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT), .EN_BIT(EN_BIT),
    .SEL_ADDR(SEL_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .eiStb(eiStb), .iretStb(iretStb),
    .diStb(diStb), .ackStb(ackStb), .strb(strb)
  );

  irq_gate_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT), .EN_BIT(EN_BIT),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .pinIn(pinIn), .cmpIn(cmpIn), .regRdData(regRdData),
    .enable(enable), .pending(pending), .irqReq(irqReq)
  );

  AST_SET_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ((eiStb || iretStb) && !diStb && !ackStb) |=> enable); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (diStb || ackStb) |=> !enable); // R7
  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ackStb |=> !irqReq); // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (pending && enable && !ackStb && !diStb && !regWrEn) |=> irqReq); // R8
endmodule

// File: tb/irq_gate_test.sv
`timescale 1ns/1ps
module irq_gate_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regAddr = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       pinIn = 1'b0;
  logic       cmpIn = 1'b0;
  logic       eiStb = 1'b0, iretStb = 1'b0, diStb = 1'b0, ackStb = 1'b0;
  logic       irqReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_gate uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .cmpIn(cmpIn), .eiStb(eiStb), .iretStb(iretStb), .diStb(diStb),
    .ackStb(ackStb), .irqReq(irqReq)
  );

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic a, logic [7:0] d);
    regAddr = a; regWrEn = 1'b1; regWrData = d;
    tick();
    regWrEn = 1'b0; regWrData = 8'h00;
  endtask

  task automatic regRead(logic a, output logic [7:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic pulse(logic e, logic r, logic d, logic k);
    eiStb = e; iretStb = r; diStb = d; ackStb = k;
    tick();
    eiStb = 0; iretStb = 0; diStb = 0; ackStb = 0;
  endtask

  // clear pending (ack), then enable
  task automatic cleanEnable();
    pulse(0, 0, 0, 1);
    pulse(1, 0, 0, 0);
  endtask

  initial begin
    logic [7:0] rv;
    #5;
    tick(); tick();
    rstN = 1'b1;
    #1;
    // R1 reset state
    regRead(0, rv); check("R1 sel reset", rv, 8'h00);
    regRead(1, rv); check("R1 ctrl reset", rv, 8'h00);
    check("R1 irq reset", {7'b0, irqReq}, 8'h00);

    // R2 / R5 reserved bits
    regWrite(0, 8'hFF); regRead(0, rv); check("R2 sel write FF", rv, 8'h40);
    regWrite(0, 8'hBF); regRead(0, rv); check("R2 sel write BF", rv, 8'h00);
    regWrite(1, 8'hFF); regRead(1, rv); check("R5 ctrl write FF", rv, 8'h80);
    regWrite(1, 8'h7F); regRead(1, rv); check("R6 ctrl write 7F", rv, 8'h00);

    // R5 R6 R7: exhaustive strobe/write combinations from both enable states
    for (int init = 0; init < 2; init++) begin
      for (int code = 0; code < 64; code++) begin
        logic e, r, d, k, w, wd, expEn;
        {e, r, d, k, w, wd} = code[5:0];
        regWrite(1, {init[0], 7'b0});
        regAddr = 1; regWrEn = w; regWrData = {wd, 7'b0};
        eiStb = e; iretStb = r; diStb = d; ackStb = k;
        tick();
        regWrEn = 0; regWrData = 0; eiStb = 0; iretStb = 0; diStb = 0; ackStb = 0;
        if (d | k)      expEn = 1'b0;
        else if (e | r) expEn = 1'b1;
        else if (w)     expEn = wd;
        else            expEn = init[0];
        regRead(1, rv);
        check((d | k) ? "R7 clear/R6" : ((e | r) ? "R7 strobe/R5" : "R5 write"),
              rv, {expEn, 7'b0});
      end
    end

    // R2 R3: source edge sweep over select and input transitions
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 16; c++) begin
        logic p0, c0, p1, c1, m0, m1;
        {p0, c0, p1, c1} = c[3:0];
        regWrite(0, {1'b0, s[0], 6'b0});
        pinIn = p0; cmpIn = c0;
        tick(); tick();
        cleanEnable();
        pinIn = p1; cmpIn = c1;
        tick();
        m0 = s[0] ? c0 : p0;
        m1 = s[0] ? c1 : p1;
        check(s[0] ? "R2 cmp R3 edge" : "R2 pin R3 edge",
              {7'b0, irqReq}, {7'b0, (!m0 && m1)});
      end
    end

    // R4: switching source produces an edge
    for (int c = 0; c < 16; c++) begin
      logic s0, s1, p, q, m0, m1;
      {s0, s1, p, q} = c[3:0];
      regWrite(0, {1'b0, s0, 6'b0});
      pinIn = p; cmpIn = q;
      tick(); tick();
      cleanEnable();
      regWrite(0, {1'b0, s1, 6'b0});
      check("R4 write cycle", {7'b0, irqReq}, 8'h00);
      tick();
      m0 = s0 ? q : p;
      m1 = s1 ? q : p;
      check("R4 switch edge", {7'b0, irqReq}, {7'b0, (!m0 && m1)});
    end

    // R8: pending recorded while disabled
    regWrite(0, 8'h00); pinIn = 0; cmpIn = 0;
    tick(); tick();
    pulse(0, 0, 0, 1);
    pinIn = 1; tick();
    check("R8 masked while disabled", {7'b0, irqReq}, 8'h00);
    tick();
    pulse(0, 1, 0, 0);
    check("R8 presented on enable", {7'b0, irqReq}, 8'h01);
    pulse(0, 0, 1, 0);
    check("R8 dropped on disable", {7'b0, irqReq}, 8'h00);
    regWrite(1, 8'h80);
    check("R8 re-presented on write", {7'b0, irqReq}, 8'h01);

    // R9: ack clears pending and enable
    pulse(0, 0, 0, 1);
    check("R9 ack drops request", {7'b0, irqReq}, 8'h00);
    regRead(1, rv); check("R9 ack clears enable", rv, 8'h00);
    pulse(1, 0, 0, 0);
    check("R9 ack cleared pending", {7'b0, irqReq}, 8'h00);
    // R9: edge in the acknowledge cycle survives
    pinIn = 0; tick();
    pinIn = 1; ackStb = 1; tick(); ackStb = 0;
    check("R9 ack cycle edge masked", {7'b0, irqReq}, 8'h00);
    pulse(1, 0, 0, 0);
    check("R9 ack cycle edge kept", {7'b0, irqReq}, 8'h01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule